// File: doc/BRIEF.md
# Channel Request Idle Timeout Timer

This block watches each transfer channel for a request line that has gone quiet for too long. Three free-running clock dividers are shared by all channels. Each channel selects one of them, or none, which turns its timer off. While the channel is enabled and neither a request nor a transfer is present, a per-channel counter counts the ticks of the selected divider. When the count reaches a power-of-two limit chosen per channel, the block emits a one-cycle timeout event. The event is meant to set the channel's timeout status flag, which is bit 6 of the channel status word held elsewhere.

The dividers are never realigned to a channel's start. The first tick after a channel begins idling can therefore come anywhere within one divider period, and every timeout has an uncertainty of one tick. A channel can optionally defer its timer. In that mode the timer holds until the channel's request has been seen going from active to inactive, so a channel that never received a request never times out.

Top module: `dma_req_timeout`

## Requirements
- R1: After a synchronous reset, all timeout event outputs are 0.
- R2: A channel whose prescale select is 0 never produces a timeout event, whatever its other inputs.
- R3: Prescale select 1, 2 and 3 pick dividers of DIV_LO, DIV_MID and DIV_HI clocks (defaults 256, 65536, 2^24). Each divider counts from reset and ticks on every clock edge e (0-based after reset) where e mod DIV equals DIV-1.
- R4: With timeout select n (3 bits), the event fires on the clock edge of the 2^(n+2)-th divider tick counted while the channel is idle. Measured in clock edges from the first idle edge, this is between (2^(n+2)-1)·DIV+1 and 2^(n+2)·DIV edges.
- R5: An active request or an active transfer strobe clears the channel's tick count, and no event follows in the next cycle. Counting restarts from zero when both are inactive again.
- R6: A disabled channel produces no event, and its count is cleared.
- R7: Each expiry gives exactly one single-cycle event. The counter then stays stopped until the channel leaves the idle state.
- R8: With wait mode set, the timer stays stopped until the request is seen going from 1 to 0. Idle counting begins on the edge after that fall is sampled. The armed state clears when the channel is disabled or its prescale select is 0.
- R9: Channels are independent. One channel's inputs do not change another channel's event output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en_i | input | NUM_CH | Per-channel enable |
| req_i | input | NUM_CH | Per-channel request line, active high |
| xfer_i | input | NUM_CH | Per-channel transfer strobe, active high |
| wait_en_i | input | NUM_CH | Per-channel wait-for-request-fall mode |
| ps_sel_i | input | 2*NUM_CH | Prescale select, 2 bits per channel (channel c at [2c+1:2c]) |
| to_sel_i | input | 3*NUM_CH | Timeout select, 3 bits per channel (channel c at [3c+2:3c]) |
| tmo_evt_o | output | NUM_CH | Registered one-cycle timeout event per channel |

## Verification
On every cycle, the assertions check that no event follows a disabled channel, a prescale select of 0, an active request or transfer, or an unarmed wait mode. They also check that events never last two cycles and that each divider tick stands alone. Only the bench's scenarios can show when an event actually fires. That covers the window of expiry against divider phase for several prescale and timeout selections, the restart after a request pulse, the deferral until a request falls, and channel independence. For those it uses a behavioural reference compared on every clock.

// File: rtl/dma_tmo_pkg.sv
package dma_tmo_pkg;

  typedef enum logic [1:0] {
    PS_OFF = 2'd0,
    PS_LO  = 2'd1,
    PS_MID = 2'd2,
    PS_HI  = 2'd3
  } ps_sel_e;

  localparam int unsigned TO_SEL_W   = 3;
  localparam int unsigned PS_SEL_W   = 2;
  localparam int unsigned NUM_DIV    = 3;
  // widest limit is 2^(2^TO_SEL_W - 1 + 2) ticks; count reaches limit-1
  localparam int unsigned TICK_CNT_W = (1 << TO_SEL_W) + 1;

  function automatic logic [TICK_CNT_W-1:0] tmo_last(input logic [TO_SEL_W-1:0] sel);
    logic [TICK_CNT_W:0] span;
    span = (TICK_CNT_W+1)'(1) << (int'(sel) + 2);
    return TICK_CNT_W'(span - 1'b1);
  endfunction

endpackage

// File: rtl/dma_tmo_divider.sv
module dma_tmo_divider #(
  parameter int unsigned DIV = 256
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);

  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_count
      logic [W-1:0] cnt_q;
      logic         wrap;

      assign wrap   = (cnt_q == W'(DIV - 1));
      assign tick_o = wrap;

      always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (wrap) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
      end

      // R3: a divider tick is never followed by another tick
      a_r3_tick_isolated: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

      // R3: the phase counter stays inside its period
      a_r3_phase_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= W'(DIV - 1));
    end
  endgenerate

endmodule

// File: rtl/dma_tmo_channel.sv
module dma_tmo_channel
  import dma_tmo_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_DIV-1:0]  tick_i,
  input  logic                en_i,
  input  logic                req_i,
  input  logic                xfer_i,
  input  logic                wait_en_i,
  input  logic [PS_SEL_W-1:0] ps_sel_i,
  input  logic [TO_SEL_W-1:0] to_sel_i,
  output logic                evt_o
);

  logic                  req_q;
  logic                  armed_q;
  logic                  fired_q;
  logic                  evt_q;
  logic [TICK_CNT_W-1:0] tcnt_q;

  logic                  timer_on;
  logic                  tick_sel;
  logic                  run;
  logic                  at_limit;
  logic                  hit;
  logic [TICK_CNT_W-1:0] last;

  assign timer_on = en_i && (ps_sel_i != PS_OFF);

  always_comb begin
    unique case (ps_sel_e'(ps_sel_i))
      PS_LO:   tick_sel = tick_i[0];
      PS_MID:  tick_sel = tick_i[1];
      PS_HI:   tick_sel = tick_i[2];
      default: tick_sel = 1'b0;
    endcase
  end

  assign run      = timer_on && !req_i && !xfer_i && (!wait_en_i || armed_q);
  assign last     = tmo_last(to_sel_i);
  assign at_limit = (tcnt_q >= last);
  assign hit      = run && tick_sel && !fired_q && at_limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      armed_q <= 1'b0;
      fired_q <= 1'b0;
      evt_q   <= 1'b0;
      tcnt_q  <= '0;
    end else begin
      req_q <= req_i;
      evt_q <= hit;

      if (!timer_on)             armed_q <= 1'b0;
      else if (req_q && !req_i)  armed_q <= 1'b1;

      if (!run) begin
        tcnt_q  <= '0;
        fired_q <= 1'b0;
      end else if (tick_sel && !fired_q) begin
        if (at_limit) begin
          fired_q <= 1'b1;
          tcnt_q  <= '0;
        end else begin
          tcnt_q  <= tcnt_q + 1'b1;
        end
      end
    end
  end

  assign evt_o = evt_q;

  // R7: an event lasts exactly one cycle
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst)
    evt_o |=> !evt_o);

  // R6: no event after a cycle with the channel disabled
  a_r6_disabled_silent: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !evt_o);

  // R2: prescale select 0 stops the timer
  a_r2_prescale_off: assert property (@(posedge clk) disable iff (rst)
    (ps_sel_i == PS_OFF) |=> !evt_o);

  // R5: request or transfer activity forbids an event next cycle
  a_r5_activity_clears: assert property (@(posedge clk) disable iff (rst)
    (req_i || xfer_i) |=> !evt_o);

  // R8: an unarmed waiting channel cannot expire
  a_r8_wait_unarmed: assert property (@(posedge clk) disable iff (rst)
    (wait_en_i && !armed_q) |=> !evt_o);

  // R7: once fired, the count is parked at zero while idle persists
  a_r7_parked_after_fire: assert property (@(posedge clk) disable iff (rst)
    fired_q |-> (tcnt_q == '0));

endmodule

// File: rtl/dma_req_timeout.sv
module dma_req_timeout
  import dma_tmo_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned DIV_LO  = 256,
  parameter int unsigned DIV_MID = 65536,
  parameter int unsigned DIV_HI  = 16777216
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_CH-1:0]            ch_en_i,
  input  logic [NUM_CH-1:0]            req_i,
  input  logic [NUM_CH-1:0]            xfer_i,
  input  logic [NUM_CH-1:0]            wait_en_i,
  input  logic [PS_SEL_W*NUM_CH-1:0]   ps_sel_i,
  input  logic [TO_SEL_W*NUM_CH-1:0]   to_sel_i,
  output logic [NUM_CH-1:0]            tmo_evt_o
);

  logic [NUM_DIV-1:0] ticks;

  generate
    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
      localparam int unsigned D = (g == 0) ? DIV_LO : (g == 1) ? DIV_MID : DIV_HI;
      dma_tmo_divider #(.DIV(D)) u_div (
        .clk    (clk),
        .rst    (rst),
        .tick_o (ticks[g])
      );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dma_tmo_channel u_ch (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (ticks),
        .en_i      (ch_en_i[c]),
        .req_i     (req_i[c]),
        .xfer_i    (xfer_i[c]),
        .wait_en_i (wait_en_i[c]),
        .ps_sel_i  (ps_sel_i[PS_SEL_W*c +: PS_SEL_W]),
        .to_sel_i  (to_sel_i[TO_SEL_W*c +: TO_SEL_W]),
        .evt_o     (tmo_evt_o[c])
      );
    end
  endgenerate

  // R1: outputs are quiet in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (tmo_evt_o == '0));

endmodule

// File: tb/dma_req_timeout_tb_top.sv
module dma_req_timeout_tb_top;

  localparam int NCH = 2;
  localparam int D1  = 4;
  localparam int D2  = 8;
  localparam int D3  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0]   en = '0, req = '0, xfer = '0, wt = '0;
  logic [2*NCH-1:0] ps = '0;
  logic [3*NCH-1:0] to = '0;
  logic [NCH-1:0]   evt;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_req_timeout #(.NUM_CH(NCH), .DIV_LO(D1), .DIV_MID(D2), .DIV_HI(D3)) dut_i (
    .clk(clk), .rst(rst), .ch_en_i(en), .req_i(req), .xfer_i(xfer),
    .wait_en_i(wt), .ps_sel_i(ps), .to_sel_i(to), .tmo_evt_o(evt));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", rq, act, exp, cyc);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // behavioural reference: edge index since reset, idle-tick tallies
  int e;
  int m_reqq[NCH], m_arm[NCH], m_ticks[NCH], m_fired[NCH];
  bit m_evt[NCH];

  always @(posedge clk) begin
    if (rst) begin
      e = 0;
      for (int c = 0; c < NCH; c++) begin
        m_reqq[c] = 0; m_arm[c] = 0; m_ticks[c] = 0; m_fired[c] = 0; m_evt[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        int p, lim, per;
        bit tk, on, idle;
        p   = int'(ps[2*c +: 2]);
        lim = 1 << (int'(to[3*c +: 3]) + 2);
        per = (p == 1) ? D1 : (p == 2) ? D2 : D3;
        tk  = (p != 0) && ((e % per) == per - 1);
        on  = en[c] && (p != 0);
        idle = on && !req[c] && !xfer[c] && (!wt[c] || m_arm[c] != 0);
        m_evt[c] = idle && tk && (m_fired[c] == 0) && (m_ticks[c] >= lim - 1);
        if (!idle) begin
          m_ticks[c] = 0; m_fired[c] = 0;
        end else if (tk && m_fired[c] == 0) begin
          if (m_ticks[c] >= lim - 1) begin m_fired[c] = 1; m_ticks[c] = 0; end
          else m_ticks[c]++;
        end
        if (!on) m_arm[c] = 0;
        else if (m_reqq[c] != 0 && !req[c]) m_arm[c] = 1;
        m_reqq[c] = req[c];
      end
      e++;
    end
  end

  // per-clock comparison against the reference (R4 R9 timing)
  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < NCH; c++)
        chk(evt[c] == m_evt[c], "R4 R9 reference", int'(evt[c]), int'(m_evt[c]));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      report();
    end
  end

  task automatic setch(input int c, input bit en_v, input int ps_v, input int to_v, input bit wt_v);
    en[c] = en_v; ps[2*c +: 2] = 2'(ps_v); to[3*c +: 3] = 3'(to_v); wt[c] = wt_v;
  endtask

  task automatic measure(input int c, input int maxc, output int n);
    n = 0;
    while (n < maxc && !evt[c]) begin @(negedge clk); n++; end
  endtask

  task automatic count_evts(input int c, input int ncyc, output int k);
    k = 0;
    for (int i = 0; i < ncyc; i++) begin @(negedge clk); if (evt[c]) k++; end
  endtask

  task automatic window(input int c, input int ps_v, input int to_v, input int per, input string rq);
    int n, lim, k;
    lim = 1 << (to_v + 2);
    @(negedge clk);
    setch(c, 1, ps_v, to_v, 0);
    measure(c, lim * per + 20, n);
    chk(n >= (lim - 1) * per + 1 && n <= lim * per, rq, n, lim * per);
    @(negedge clk);
    chk(evt[c] == 1'b0, "R7 pulse width", int'(evt[c]), 0);
    count_evts(c, 3 * lim * per / 2, k);
    chk(k == 0, "R7 no repeat", k, 0);
    setch(c, 0, 0, 0, 0);
  endtask

  initial begin
    int n, k;
    repeat (3) @(negedge clk);
    chk(evt == '0, "R1 reset", int'(evt), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(evt == '0, "R1 after reset", int'(evt), 0);

    // R3 R4: several divider / limit pairs
    window(0, 1, 0, D1, "R4 ps1 to0 window");
    repeat (3) @(negedge clk);
    window(0, 2, 1, D2, "R3 ps2 to1 window");
    repeat (5) @(negedge clk);
    window(0, 3, 0, D3, "R3 ps3 to0 window");
    window(1, 1, 7, D1, "R4 ps1 to7 window");

    // R2: prescale off
    @(negedge clk); setch(0, 1, 0, 0, 0);
    count_evts(0, 200, k); chk(k == 0, "R2 prescale off", k, 0);

    // R6: disabled with everything else set
    setch(0, 0, 1, 0, 0);
    count_evts(0, 100, k); chk(k == 0, "R6 disabled", k, 0);

    // R5: held request, then periodic transfers
    req[0] = 1'b1; setch(0, 1, 1, 0, 0);
    count_evts(0, 100, k); chk(k == 0, "R5 request held", k, 0);
    req[0] = 1'b0;
    for (int i = 0; i < 12; i++) begin
      count_evts(0, 9, k); chk(k == 0, "R5 transfers restart", k, 0);
      xfer[0] = 1'b1; @(negedge clk); xfer[0] = 1'b0;
    end
    measure(0, 40, n);
    chk(n >= 3 * D1 + 1 && n <= 4 * D1, "R5 restart after transfer", n, 4 * D1);
    // R5: request pulse restarts a fired channel
    repeat (5) @(negedge clk);
    req[0] = 1'b1; @(negedge clk); req[0] = 1'b0;
    measure(0, 40, n);
    chk(n >= 3 * D1 + 1 && n <= 4 * D1, "R5 restart after request", n, 4 * D1);
    setch(0, 0, 0, 0, 0);

    // R8: wait mode defers until request falls
    @(negedge clk); setch(0, 1, 1, 0, 1);
    count_evts(0, 100, k); chk(k == 0, "R8 waiting", k, 0);
    req[0] = 1'b1; repeat (3) @(negedge clk); req[0] = 1'b0;
    measure(0, 40, n);
    chk(n >= 3 * D1 + 2 && n <= 4 * D1 + 1, "R8 after fall", n, 4 * D1 + 1);
    setch(0, 0, 0, 0, 1);
    @(negedge clk); setch(0, 1, 1, 0, 1);
    count_evts(0, 60, k); chk(k == 0, "R8 rearm after disable", k, 0);
    setch(0, 0, 0, 0, 0);

    // R9: channel 1 runs while channel 0 is held off
    @(negedge clk); setch(1, 1, 1, 0, 0); req[0] = 1'b1; setch(0, 1, 1, 0, 0);
    measure(1, 40, n);
    chk(n >= 3 * D1 + 1 && n <= 4 * D1, "R9 ch1 fires", n, 4 * D1);
    chk(evt[0] == 1'b0, "R9 ch0 quiet", int'(evt[0]), 0);
    req[0] = 1'b0; setch(0, 0, 0, 0, 0); setch(1, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    report();
  end

endmodule